// File: doc/BRIEF.md
# Programmable Bus Address Event Detector

The block watches one address stream, such as a memory bus or a snoop channel. It compares every valid address against a small set of programmable match entries. Each entry stores an address pattern and an ignore mask, so one entry can cover an aligned range or a scattered set of addresses. Hits are not filtered any further. A range that also covers unwanted addresses still produces a notify, and a later stage has to decide whether the hit was of interest.

When several enabled entries hit in the same cycle, the one with the lowest index is reported. Only that entry's decimation counter advances. Each entry has its own decimation count N, and the entry emits a one-cycle notify pulse only on every Nth reported hit. This keeps a busy event from flooding the monitor core.

An entry can also be marked as a watchpoint. Its notify is then flagged high priority, and the block raises a stall request toward the execution core. The request stays up until the monitor answers with a continue or a take-over pulse. Software programs the entries through a single command port, and every entry is disabled at reset.

Top module: `bus_watch_unit`

## Requirements
- R1: An enabled entry hits when every address bit whose ignore-mask bit is 0 equals the stored pattern bit. Mask bits set to 1 are ignored, and the matched set need not be contiguous. Command code 0 writes the pattern and code 1 writes the ignore mask, both taken from `cfg_data` for the entry chosen by `cfg_idx`.
- R2: After reset every entry is disabled and produces no notify, whatever address is seen. Command code 3 writes the control field: bit 0 enables the entry and bit 1 marks it as a watchpoint. Writing bit 0 as 0 disables the entry again.
- R3: If several enabled entries hit in one cycle, the lowest-numbered one is reported. Only that entry's decimation counter advances.
- R4: Command code 2 writes the decimation count N from the low `CNT_W` bits of `cfg_data`. An entry emits a notify on every Nth reported hit, and an N of 0 or 1 means every hit. The hit counter clears after each emitted notify and whenever N is rewritten.
- R5: `ntf_valid` is high for exactly the one cycle after the cycle in which the emitting hit was presented, with `ntf_idx` holding the entry index. A cycle without a valid address produces no notify in the next cycle.
- R6: A notify from a watchpoint entry has `ntf_high` at 1 and raises `stall_req` in the same cycle. Other notifies have `ntf_high` at 0 and leave `stall_req` unchanged.
- R7: `stall_req` stays high until `mon_continue` or `mon_takeover` is sampled high, and it is low from the next cycle on. A watchpoint notify that arrives in that same cycle keeps it high.
- R8: During and right after reset, `ntf_valid`, `ntf_high` and `stall_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Command strobe |
| cfg_op | input | 2 | Command code: 0 pattern, 1 ignore mask, 2 decimation count, 3 control |
| cfg_idx | input | IDX_W | Target entry of the command |
| cfg_data | input | ADDR_W | Command data |
| bus_valid | input | 1 | Observed address is valid this cycle |
| bus_addr | input | ADDR_W | Observed address |
| mon_continue | input | 1 | Monitor lets the stalled core continue |
| mon_takeover | input | 1 | Monitor takes over; also ends the stall |
| ntf_valid | output | 1 | One-cycle notify pulse |
| ntf_idx | output | IDX_W | Entry that produced the notify |
| ntf_high | output | 1 | Notify is high priority (watchpoint) |
| stall_req | output | 1 | Stall request to the execution core |

## Verification
The assertions watch the notify and stall handshake on every cycle:
- no notify follows a cycle without a valid address;
- every notify comes from an entry that was enabled;
- a stall rises only together with a high-priority notify, and every high-priority notify comes with a stall;
- a stall holds until it is released and then drops.

Which entry wins, which addresses fall inside a masked range, and on which hit the decimation lets a notify through all depend on programmed contents. The bench shows these with full sweeps of the address space against an arithmetic model, and with hit sequences that rewrite the decimation count part way through.

// File: rtl/bwu_pkg.sv
// Package: shared command codes and control-field bit positions for the
// bus address event detector.
package bwu_pkg;
    typedef enum logic [1:0] {
        OP_PATTERN = 2'd0,
        OP_IGNORE  = 2'd1,
        OP_DIVIDE  = 2'd2,
        OP_CONTROL = 2'd3
    } cfg_op_e;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_WATCH_BIT = 1;
endpackage

// File: rtl/bwu_entry.sv
// Module: one ternary match entry.
// Holds a pattern, an ignore mask (1 = bit ignored) and the enable and
// watchpoint flags, and reports a hit for the current bus address.
// Assumes that writes are single-cycle strobes already decoded for this entry.
module bwu_entry #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pat,
    input  logic              wr_ign,
    input  logic              wr_ctl,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output logic              en,
    output logic              watch
);
    import bwu_pkg::*;

    logic [ADDR_W-1:0] pat_q;
    logic [ADDR_W-1:0] ign_q;

    // Store the pattern, ignore mask and control flags; everything is off at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
            ign_q <= '0;
            en    <= 1'b0;
            watch <= 1'b0;
        end else begin
            if (wr_pat) pat_q <= wr_data;
            if (wr_ign) ign_q <= wr_data;
            if (wr_ctl) begin
                en    <= wr_data[CTL_EN_BIT];
                watch <= wr_data[CTL_WATCH_BIT];
            end
        end
    end

    // Compare only the cared-for bits of the address.
    always_comb begin
        hit = en && bus_valid && (((bus_addr ^ pat_q) & ~ign_q) == '0);
    end
endmodule

// File: rtl/bwu_decim.sv
// Module: decimation counter for one entry.
// Lets every Nth selected hit fire (N of 0 or 1 fires on every hit).
// The counter clears on each firing and on every rewrite of N; a rewrite in
// the same cycle as a hit wins and suppresses that firing.
module bwu_decim #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_div,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             sel,
    output logic             fire
);
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // Decide whether the current hit completes the count.
    always_comb begin
        last = (div_q <= CNT_W'(1)) || (cnt_q == div_q - CNT_W'(1));
        fire = sel && last && !wr_div;
    end

    // Hold N and count selected hits toward it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (wr_div) begin
            div_q <= wr_val;
            cnt_q <= '0;
        end else if (sel) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/bwu_pick.sv
// Module: fixed-priority selector.
// Picks the lowest-numbered hit and returns it both as a one-hot vector and
// as an index. Purely combinational.
module bwu_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     hit,
    output logic [N-1:0]     sel,
    output logic [IDX_W-1:0] idx
);
    logic lower;

    // One-hot of the first set bit, scanning upward from index 0.
    always_comb begin
        lower = 1'b0;
        for (int i = 0; i < N; i++) begin
            sel[i] = hit[i] && !lower;
            lower  = lower | hit[i];
        end
    end

    // Index of the lowest set bit, scanning downward so the lowest is kept.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/bwu_stall.sv
// Module: stall handshake toward the execution core.
// Sets on a watchpoint notify and clears on a continue or take-over pulse.
// A set in the same cycle as a release wins.
module bwu_stall (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic release_i,
    output logic stall_o
);
    // Hold the request until the monitor answers.
    always_ff @(posedge clk) begin
        if (!rst_n)         stall_o <= 1'b0;
        else if (set_i)     stall_o <= 1'b1;
        else if (release_i) stall_o <= 1'b0;
    end
endmodule

// File: rtl/bus_watch_unit.sv
// Module: bus address event detector (top).
// Matches each valid bus address against NUM_ENTRIES ternary entries,
// reports the lowest-numbered hit through a per-entry decimation counter as
// a one-cycle registered notify, and raises a stall on watchpoint notifies.
// Assumes one command per cycle on the command port and NUM_ENTRIES >= 2.
module bus_watch_unit #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_op,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              mon_continue,
    input  logic              mon_takeover,
    output logic              ntf_valid,
    output logic [IDX_W-1:0]  ntf_idx,
    output logic              ntf_high,
    output logic              stall_req
);
    import bwu_pkg::*;

    cfg_op_e               op;
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [NUM_ENTRIES-1:0] en_vec;
    logic [NUM_ENTRIES-1:0] watch_vec;
    logic [NUM_ENTRIES-1:0] sel_vec;
    logic [NUM_ENTRIES-1:0] fire_vec;
    logic [IDX_W-1:0]       pick_idx;
    logic                   any_fire;
    logic                   watch_fire;

    // Decode the command code.
    always_comb op = cfg_op_e'(cfg_op);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        logic addr_me;
        // Command addresses this entry.
        always_comb addr_me = cfg_valid && (cfg_idx == IDX_W'(g));

        bwu_entry #(.ADDR_W(ADDR_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_pat    (addr_me && op == OP_PATTERN),
            .wr_ign    (addr_me && op == OP_IGNORE),
            .wr_ctl    (addr_me && op == OP_CONTROL),
            .wr_data   (cfg_data),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .hit       (hit_vec[g]),
            .en        (en_vec[g]),
            .watch     (watch_vec[g])
        );

        bwu_decim #(.CNT_W(CNT_W)) u_decim (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_div (addr_me && op == OP_DIVIDE),
            .wr_val (cfg_data[CNT_W-1:0]),
            .sel    (sel_vec[g]),
            .fire   (fire_vec[g])
        );
    end

    bwu_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hit (hit_vec),
        .sel (sel_vec),
        .idx (pick_idx)
    );

    // Collapse the per-entry firings; at most one can be set.
    always_comb begin
        any_fire   = |fire_vec;
        watch_fire = |(fire_vec & watch_vec);
    end

    // Register the notify so it appears one cycle after the hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_valid <= 1'b0;
            ntf_idx   <= '0;
            ntf_high  <= 1'b0;
        end else begin
            ntf_valid <= any_fire;
            ntf_idx   <= any_fire ? pick_idx : '0;
            ntf_high  <= watch_fire;
        end
    end

    bwu_stall u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (watch_fire),
        .release_i (mon_continue || mon_takeover),
        .stall_o   (stall_req)
    );
endmodule

// File: rtl/bwu_checker.sv
// Module: protocol checker for bus_watch_unit, attached by bind.
// Checks the notify timing, the enable gating and the stall handshake.
module bwu_checker #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   mon_continue,
    input logic                   mon_takeover,
    input logic                   ntf_valid,
    input logic [IDX_W-1:0]       ntf_idx,
    input logic                   ntf_high,
    input logic                   stall_req,
    input logic [NUM_ENTRIES-1:0] en_vec
);
    logic [NUM_ENTRIES-1:0] en_q;

    // Enable flags as they stood in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_vec;
    end

    // R5: no valid address, no notify in the next cycle
    a_r5_notify_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !ntf_valid);

    // R2: a notify only comes from an entry enabled during the hit cycle
    a_r2_notify_from_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> en_q[ntf_idx]);

    // R6: a high-priority notify comes with a stall request
    a_r6_watch_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && ntf_high) |-> stall_req);

    // R6: a stall only rises with a high-priority notify
    a_r6_stall_rise_is_watch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_req) |-> (ntf_valid && ntf_high));

    // R6: the priority flag never stands without a notify
    a_r6_high_needs_notify: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_high |-> ntf_valid);

    // R7: the stall holds while the monitor has not answered
    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && !mon_continue && !mon_takeover) |=> stall_req);

    // R7: an answer drops the stall unless a new watchpoint notify arrives
    a_r7_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && (mon_continue || mon_takeover)) |=> (!stall_req || (ntf_valid && ntf_high)));
endmodule

bind bus_watch_unit bwu_checker #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .mon_continue (mon_continue),
    .mon_takeover (mon_takeover),
    .ntf_valid    (ntf_valid),
    .ntf_idx      (ntf_idx),
    .ntf_high     (ntf_high),
    .stall_req    (stall_req),
    .en_vec       (en_vec)
);

// File: tb/sim_bus_watch_unit.sv
// Bench: sweeps the whole address space of a small configuration and compares
// the outputs with an arithmetic model of the entries.
module sim_bus_watch_unit;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_op = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          mon_continue = 1'b0;
    logic          mon_takeover = 1'b0;
    logic          ntf_valid;
    logic [IW-1:0] ntf_idx;
    logic          ntf_high;
    logic          stall_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model state
    int m_pat[N];
    int m_ign[N];
    bit m_en[N];
    bit m_wp[N];
    int m_div[N];
    int m_cnt[N];
    bit m_stall = 1'b0;

    always #4 clk = ~clk;

    bus_watch_unit #(.NUM_ENTRIES(N), .ADDR_W(AW), .CNT_W(CW)) u0 (.*);

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(int op, int idx, int data);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = 2'(op); cfg_idx = IW'(idx); cfg_data = AW'(data);
        @(negedge clk);
        cfg_valid = 1'b0;
        case (op)
            0: m_pat[idx] = data;
            1: m_ign[idx] = data;
            2: begin m_div[idx] = data % (1 << CW); m_cnt[idx] = 0; end
            default: begin m_en[idx] = data[0]; m_wp[idx] = data[1]; end
        endcase
    endtask

    // Present one address, then compare the next cycle's outputs with the model.
    task automatic hit(int addr, string req);
        int k;
        bit ev, eh;
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = AW'(addr);
        k = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_en[i] && (((addr ^ m_pat[i]) & ~m_ign[i] & ((1 << AW) - 1)) == 0)) k = i;
        ev = 1'b0; eh = 1'b0;
        if (k >= 0) begin
            if (m_div[k] <= 1 || m_cnt[k] == m_div[k] - 1) begin
                ev = 1'b1; m_cnt[k] = 0; eh = m_wp[k];
            end else m_cnt[k]++;
        end
        if (eh) m_stall = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        check({req, " notify"}, int'(ntf_valid), int'(ev));
        if (ev) begin
            check({req, " index"}, int'(ntf_idx), k);
            check({req, " priority"}, int'(ntf_high), int'(eh));
        end
        check({req, " stall"}, int'(stall_req), int'(m_stall));
    endtask

    task automatic answer(bit take);
        @(negedge clk);
        if (take) mon_takeover = 1'b1; else mon_continue = 1'b1;
        @(negedge clk);
        mon_takeover = 1'b0; mon_continue = 1'b0;
        m_stall = 1'b0;
        check("R7 release", int'(stall_req), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_pat[i] = 0; m_ign[i] = 0; m_en[i] = 0; m_wp[i] = 0; m_div[i] = 0; m_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset
        check("R8 notify in reset", int'(ntf_valid), 0);
        check("R8 stall in reset", int'(stall_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 notify after reset", int'(ntf_valid), 0);
        check("R8 priority after reset", int'(ntf_high), 0);
        check("R8 stall after reset", int'(stall_req), 0);

        // R2: patterns written but nothing enabled -> silent over every address
        cfg(0, 0, 8'h40); cfg(1, 0, 8'h0F);
        cfg(0, 1, 8'h48);
        cfg(0, 2, 8'h00); cfg(1, 2, 8'hFF);
        cfg(0, 3, 8'hA5);
        for (int a = 0; a < 256; a++) hit(a, "R2 disabled");

        // R1 R3: all enabled, overlapping ranges, lowest index wins
        for (int i = 0; i < N; i++) cfg(3, i, 1);
        for (int a = 0; a < 256; a++) hit(a, "R3 priority sweep");

        // R1: drop the catch-all; non-contiguous masked set on entry 1
        cfg(3, 2, 0);
        cfg(0, 1, 8'h30); cfg(1, 1, 8'h05);
        for (int a = 0; a < 256; a++) hit(a, "R1 ternary sweep");

        // R4: every third hit on entry 0, with a rewrite mid-count
        cfg(2, 0, 3);
        for (int j = 0; j < 9; j++) hit(8'h41, "R4 decimate");
        hit(8'h42, "R4 before rewrite");
        hit(8'h43, "R4 before rewrite");
        cfg(2, 0, 3);
        for (int j = 0; j < 4; j++) hit(8'h44, "R4 after rewrite");
        // R4: larger count, other address set hits on entry 1
        cfg(2, 1, 5);
        for (int j = 0; j < 12; j++) hit(8'h34, "R4 count five");

        // R5: a cycle with no valid address gives no notify
        @(negedge clk);
        @(negedge clk);
        check("R5 idle", int'(ntf_valid), 0);

        // R6 R7: watchpoint on entry 3, hold, then release by continue
        cfg(3, 3, 3);
        hit(8'hA5, "R6 watch");
        repeat (5) @(negedge clk);
        check("R7 hold", int'(stall_req), 1);
        hit(8'h41, "R6 normal during stall");
        answer(1'b0);
        // R7: release by take-over
        hit(8'hA5, "R6 watch again");
        repeat (3) @(negedge clk);
        check("R7 hold again", int'(stall_req), 1);
        answer(1'b1);
        // R7: release in the same cycle as a new watchpoint hit -> stays high
        hit(8'hA5, "R6 watch third");
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 8'hA5; mon_continue = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; mon_continue = 1'b0;
        check("R7 set beats release", int'(stall_req), 1);
        check("R6 high on coincident", int'(ntf_high), 1);
        answer(1'b0);

        // R2: disabling an entry silences it
        cfg(3, 0, 0);
        hit(8'h41, "R2 disabled again");
        finish_run();
    end
endmodule